// File: doc/BRIEF.md
# Lifecycle Transition Controller

This block holds the lifecycle state of a device and moves it forward on request. After reset it stays in a waiting state. It leaves that state only when an initialization request arrives together with valid state and count data from nonvolatile storage. Once initialized, it drives three enable outputs from the current lifecycle state and shows the state code and the transition count.

Software asks for a move by presenting a target state code and a token, then pulsing a start command. The block checks the request in a fixed order: the count limit first, then whether the arc is legal, then the token. If every check passes, it writes to storage in two steps. The first write carries the incremented count with the old state, and the second carries the new state. Any finished request leaves the block in a terminal state. Any error during programming, any corrupt persisted data and any escalation input lead to an escalation state instead. Only reset leaves either of these states.

FSM states and arcs:
- `F_WAIT` → `F_IDLE` when initialization succeeds, or `F_WAIT` → `F_ESC` when the persisted data is bad.
- `F_IDLE` → `F_CNTW` when a request is accepted, or `F_IDLE` → `F_DONE` when a request fails a check.
- `F_CNTW` → `F_STW` when the count write is acknowledged.
- `F_STW` → `F_DONE` when the state write is acknowledged.
- `F_CNTW` or `F_STW` → `F_ESC` on a programming error.
- Any state → `F_ESC` on `esc_in`.
- An FSM code outside the defined set → `F_ESC`.

Top module: `lcx_ctrl`

## Requirements
- R1: After reset the block waits. `st_ready`, `init_ack`, `st_busy`, `prog_req` and all three enables are 0, and `cur_state` and `cur_count` read 0. This holds until a clock edge sees `init_req` and `pers_valid` both high.
- R2: Initialization with valid data behaves as follows.
  - On the edge after the request, `st_ready` goes to 1 and `init_ack` pulses for exactly one cycle.
  - `cur_state` and `cur_count` show the persisted values.
  - The 16-bit state codes are 0x5A1E blank, 0xA3C5 test, 0x3C96 develop, 0xC969 production, 0x96F0 return and 0x6F0F scrapped.
  - The enables {dbg_en, func_en, key_en} are 000 for blank, 100 for test, 010 for develop, 011 for production, 111 for return and 000 for scrapped.
  - The enables are driven only while `st_ready` is 1.
- R3: The legal arcs are:
  - blank → test
  - test → develop
  - test → production
  - develop → production
  - develop → return
  - production → return
  - any state except scrapped → scrapped

  A target that is not a legal arc, or is not one of the six codes, sets the sticky `st_trans_err` and starts no programming.
- R4: All legal arcs except blank → test and → scrapped are conditional. They need `req_token` equal to `exp_token`; otherwise `st_tok_err` is set and nothing is programmed. The unconditional arcs ignore the token.
- R5: A request made while the count is 16 or more sets `st_cnt_err`. The checks run in priority order: count, then arc, then token. Exactly one of `st_ok`, `st_cnt_err`, `st_trans_err` and `st_tok_err` can be set after a request.
- R6: An accepted request programs in two steps.
  - First `prog_req` is raised with `prog_count` = count+1 and `prog_state` = current code.
  - After an error-free `prog_ack`, `cur_count` becomes count+1 and `prog_state` switches to the target code.
  - After a second error-free `prog_ack`, `st_ok` is set and `cur_state` shows the target.
- R7: Once any request has finished, whether it succeeded or failed a check, `st_ready` and all enables stay 0. Further `req_start` pulses are ignored until reset: no `prog_req`, and status, `cur_state` and `cur_count` are unchanged.
- R8: A `prog_ack` with `prog_err` high has the following effects.
  - `st_prog_err` is set and `alert_prog` pulses for one cycle.
  - The block enters escalation, with enables and ready at 0.
  - A count already written stays consumed in `cur_count`.
- R9: Bad data at initialization, or an FSM register holding a code outside its set, sets `st_state_err`, pulses `alert_state` for one cycle and enters escalation. Bad data means a persisted state code outside the six defined codes, or a count above 16.
- R10: `st_data_err` follows `pers_err` one cycle later and clears when `pers_err` drops. It does not block initialization or transitions.
- R11: `esc_in` has the following effects.
  - `esc_en` goes high on the next edge and stays high until reset.
  - The block enters escalation from any state, dropping enables, `st_ready`, `st_busy` and any pending `prog_req`.
- R12: `prog_req` and `st_busy` are high only while a write is outstanding. `prog_state` and `prog_count` stay stable until that write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Initialization request |
| pers_valid | input | 1 | Persisted data is valid |
| pers_state | input | 16 | Persisted lifecycle state code |
| pers_count | input | CNT_W (5) | Persisted transition count |
| pers_err | input | 1 | Error flag on persisted data |
| init_ack | output | 1 | One-cycle initialization done pulse |
| req_start | input | 1 | Start a transition request |
| req_target | input | 16 | Requested target state code |
| req_token | input | TOKEN_W (32) | Token supplied with the request |
| exp_token | input | TOKEN_W (32) | Expected token |
| prog_req | output | 1 | Storage write request |
| prog_state | output | 16 | State code to write |
| prog_count | output | CNT_W (5) | Count to write |
| prog_ack | input | 1 | Storage write acknowledge |
| prog_err | input | 1 | Storage write error, qualified by `prog_ack` |
| esc_in | input | 1 | Escalation request |
| esc_en | output | 1 | Sticky escalation enable |
| dbg_en | output | 1 | Debug enable |
| func_en | output | 1 | Functional enable |
| key_en | output | 1 | Key-use enable |
| cur_state | output | 16 | Current state code |
| cur_count | output | CNT_W (5) | Current transition count |
| st_ready | output | 1 | Idle and accepting requests |
| st_busy | output | 1 | Programming in progress |
| st_ok | output | 1 | Sticky: transition succeeded |
| st_cnt_err | output | 1 | Sticky: count limit reached |
| st_trans_err | output | 1 | Sticky: illegal target |
| st_tok_err | output | 1 | Sticky: token mismatch |
| st_prog_err | output | 1 | Sticky: programming error |
| st_state_err | output | 1 | Sticky: corrupt state data |
| st_data_err | output | 1 | Persisted-data error flag |
| alert_prog | output | 1 | Programming-failure alert pulse |
| alert_state | output | 1 | State-failure alert pulse |

## Verification
Several properties hold on every cycle and are checked by assertions:
- The enables are quiet whenever the block is not ready, and stay quiet after a finished request or under escalation.
- At most one request verdict is ever set.
- Alerts coincide with their error bits.
- `esc_en` never falls.
- The write payload holds still until it is acknowledged.

Only the bench scenarios can show the rest:
- The enable table per state.
- The legal-arc set and the order in which the checks take priority.
- The exact count and state values written in each phase.
- That a request after completion is ignored.
- That `st_data_err` clears without reset.

// File: rtl/lcx_pkg.sv
package lcx_pkg;

    localparam int CODE_W = 16;
    localparam int LC_NUM = 6;

    typedef enum logic [2:0] {
        LC_BLANK = 3'd0,
        LC_TEST  = 3'd1,
        LC_DEV   = 3'd2,
        LC_PROD  = 3'd3,
        LC_RMA   = 3'd4,
        LC_SCRAP = 3'd5
    } lc_idx_e;

    // Sparse FSM encoding; any other value is treated as corruption
    typedef enum logic [5:0] {
        F_WAIT = 6'b010101,
        F_IDLE = 6'b101001,
        F_CNTW = 6'b110010,
        F_STW  = 6'b001110,
        F_DONE = 6'b011011,
        F_ESC  = 6'b100110
    } fsm_e;

    typedef enum logic [1:0] {
        VD_OK  = 2'd0,
        VD_CNT = 2'd1,
        VD_ARC = 2'd2,
        VD_TOK = 2'd3
    } verdict_e;

    typedef struct packed {
        logic dbg;
        logic func;
        logic key;
    } lc_en_t;

    function automatic logic [CODE_W-1:0] idx2code(input lc_idx_e idx);
        logic [CODE_W-1:0] c;
        unique case (idx)
            LC_BLANK: c = 16'h5A1E;
            LC_TEST:  c = 16'hA3C5;
            LC_DEV:   c = 16'h3C96;
            LC_PROD:  c = 16'hC969;
            LC_RMA:   c = 16'h96F0;
            LC_SCRAP: c = 16'h6F0F;
            default:  c = '0;
        endcase
        return c;
    endfunction

    function automatic lc_en_t idx2en(input lc_idx_e idx);
        lc_en_t e;
        unique case (idx)
            LC_TEST: e = '{dbg: 1'b1, func: 1'b0, key: 1'b0};
            LC_DEV:  e = '{dbg: 1'b0, func: 1'b1, key: 1'b0};
            LC_PROD: e = '{dbg: 1'b0, func: 1'b1, key: 1'b1};
            LC_RMA:  e = '{dbg: 1'b1, func: 1'b1, key: 1'b1};
            default: e = '{dbg: 1'b0, func: 1'b0, key: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lcx_code_decode.sv
module lcx_code_decode
    import lcx_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              valid,
    output lc_idx_e           idx
);

    always_comb begin
        valid = 1'b0;
        idx   = LC_BLANK;
        for (int i = 0; i < LC_NUM; i++) begin
            if (code == idx2code(lc_idx_e'(i))) begin
                valid = 1'b1;
                idx   = lc_idx_e'(i);
            end
        end
    end

endmodule

// File: rtl/lcx_arc_check.sv
module lcx_arc_check
    import lcx_pkg::*;
#(
    parameter int TOKEN_W = 32,
    parameter int CNT_MAX = 16,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  lc_idx_e            cur_idx,
    input  logic [CNT_W-1:0]   cur_count,
    input  logic               tgt_valid,
    input  lc_idx_e            tgt_idx,
    input  logic [TOKEN_W-1:0] req_token,
    input  logic [TOKEN_W-1:0] exp_token,
    output verdict_e           verdict
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(CNT_MAX);

    logic legal;
    logic cond;

    always_comb begin
        legal = 1'b0;
        unique case (cur_idx)
            LC_BLANK: legal = (tgt_idx == LC_TEST)  || (tgt_idx == LC_SCRAP);
            LC_TEST:  legal = (tgt_idx == LC_DEV)   || (tgt_idx == LC_PROD) ||
                              (tgt_idx == LC_SCRAP);
            LC_DEV:   legal = (tgt_idx == LC_PROD)  || (tgt_idx == LC_RMA)  ||
                              (tgt_idx == LC_SCRAP);
            LC_PROD:  legal = (tgt_idx == LC_RMA)   || (tgt_idx == LC_SCRAP);
            LC_RMA:   legal = (tgt_idx == LC_SCRAP);
            default:  legal = 1'b0;
        endcase
        legal = legal && tgt_valid;
        cond  = !((cur_idx == LC_BLANK && tgt_idx == LC_TEST) || (tgt_idx == LC_SCRAP));
    end

    always_comb begin
        if (cur_count >= CNT_LIMIT) begin
            verdict = VD_CNT;
        end else if (!legal) begin
            verdict = VD_ARC;
        end else if (cond && (req_token != exp_token)) begin
            verdict = VD_TOK;
        end else begin
            verdict = VD_OK;
        end
    end

endmodule

// File: rtl/lcx_ctrl.sv
module lcx_ctrl
    import lcx_pkg::*;
#(
    parameter int TOKEN_W = 32,
    parameter int CNT_MAX = 16,
    localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_req,
    input  logic               pers_valid,
    input  logic [15:0]        pers_state,
    input  logic [CNT_W-1:0]   pers_count,
    input  logic               pers_err,
    output logic               init_ack,
    input  logic               req_start,
    input  logic [15:0]        req_target,
    input  logic [TOKEN_W-1:0] req_token,
    input  logic [TOKEN_W-1:0] exp_token,
    output logic               prog_req,
    output logic [15:0]        prog_state,
    output logic [CNT_W-1:0]   prog_count,
    input  logic               prog_ack,
    input  logic               prog_err,
    input  logic               esc_in,
    output logic               esc_en,
    output logic               dbg_en,
    output logic               func_en,
    output logic               key_en,
    output logic [15:0]        cur_state,
    output logic [CNT_W-1:0]   cur_count,
    output logic               st_ready,
    output logic               st_busy,
    output logic               st_ok,
    output logic               st_cnt_err,
    output logic               st_trans_err,
    output logic               st_tok_err,
    output logic               st_prog_err,
    output logic               st_state_err,
    output logic               st_data_err,
    output logic               alert_prog,
    output logic               alert_state
);

    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(CNT_MAX);

    fsm_e             fsm_q, fsm_d;
    lc_idx_e          cur_idx_q, tgt_idx_q;
    logic [CNT_W-1:0] cnt_q, pcnt_q;
    logic [15:0]      pstate_q;
    logic             valid_q;

    logic    pers_code_ok, tgt_code_ok, pers_ok;
    lc_idx_e pers_idx, tgt_idx;
    verdict_e verdict;

    // event strobes from the next-state logic
    logic ev_init_ok, ev_init_bad, ev_acc, ev_cnt_err, ev_arc_err, ev_tok_err;
    logic ev_cnt_done, ev_done, ev_prog_fail, ev_fsm_bad;

    lcx_code_decode u_pers_dec (
        .code  (pers_state),
        .valid (pers_code_ok),
        .idx   (pers_idx)
    );

    lcx_code_decode u_tgt_dec (
        .code  (req_target),
        .valid (tgt_code_ok),
        .idx   (tgt_idx)
    );

    lcx_arc_check #(
        .TOKEN_W (TOKEN_W),
        .CNT_MAX (CNT_MAX),
        .CNT_W   (CNT_W)
    ) u_arc (
        .cur_idx   (cur_idx_q),
        .cur_count (cnt_q),
        .tgt_valid (tgt_code_ok),
        .tgt_idx   (tgt_idx),
        .req_token (req_token),
        .exp_token (exp_token),
        .verdict   (verdict)
    );

    assign pers_ok = pers_code_ok && (pers_count <= CNT_LIMIT);

    // next-state logic
    always_comb begin
        fsm_d        = fsm_q;
        ev_init_ok   = 1'b0;
        ev_init_bad  = 1'b0;
        ev_acc       = 1'b0;
        ev_cnt_err   = 1'b0;
        ev_arc_err   = 1'b0;
        ev_tok_err   = 1'b0;
        ev_cnt_done  = 1'b0;
        ev_done      = 1'b0;
        ev_prog_fail = 1'b0;
        ev_fsm_bad   = 1'b0;
        if (esc_in) begin
            fsm_d = F_ESC;
        end else begin
            unique case (fsm_q)
                F_WAIT: begin
                    if (init_req && pers_valid) begin
                        if (pers_ok) begin
                            fsm_d      = F_IDLE;
                            ev_init_ok = 1'b1;
                        end else begin
                            fsm_d       = F_ESC;
                            ev_init_bad = 1'b1;
                        end
                    end
                end
                F_IDLE: begin
                    if (req_start) begin
                        unique case (verdict)
                            VD_OK:  begin fsm_d = F_CNTW; ev_acc     = 1'b1; end
                            VD_CNT: begin fsm_d = F_DONE; ev_cnt_err = 1'b1; end
                            VD_ARC: begin fsm_d = F_DONE; ev_arc_err = 1'b1; end
                            VD_TOK: begin fsm_d = F_DONE; ev_tok_err = 1'b1; end
                            default: begin fsm_d = F_DONE; ev_arc_err = 1'b1; end
                        endcase
                    end
                end
                F_CNTW: begin
                    if (prog_ack) begin
                        if (prog_err) begin
                            fsm_d        = F_ESC;
                            ev_prog_fail = 1'b1;
                        end else begin
                            fsm_d       = F_STW;
                            ev_cnt_done = 1'b1;
                        end
                    end
                end
                F_STW: begin
                    if (prog_ack) begin
                        if (prog_err) begin
                            fsm_d        = F_ESC;
                            ev_prog_fail = 1'b1;
                        end else begin
                            fsm_d   = F_DONE;
                            ev_done = 1'b1;
                        end
                    end
                end
                F_DONE: fsm_d = F_DONE;
                F_ESC:  fsm_d = F_ESC;
                default: begin
                    fsm_d      = F_ESC;
                    ev_fsm_bad = 1'b1;
                end
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q     <= F_WAIT;
            cur_idx_q <= LC_BLANK;
            tgt_idx_q <= LC_BLANK;
            cnt_q     <= '0;
            pcnt_q    <= '0;
            pstate_q  <= '0;
            valid_q   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
            if (ev_init_ok) begin
                cur_idx_q <= pers_idx;
                cnt_q     <= pers_count;
                valid_q   <= 1'b1;
            end
            if (ev_acc) begin
                tgt_idx_q <= tgt_idx;
                pcnt_q    <= cnt_q + 1'b1;
                pstate_q  <= idx2code(cur_idx_q);
            end
            if (ev_cnt_done) begin
                cnt_q    <= pcnt_q;
                pstate_q <= idx2code(tgt_idx_q);
            end
            if (ev_done) begin
                cur_idx_q <= tgt_idx_q;
            end
        end
    end

    // status, alerts and escalation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_ok        <= 1'b0;
            st_cnt_err   <= 1'b0;
            st_trans_err <= 1'b0;
            st_tok_err   <= 1'b0;
            st_prog_err  <= 1'b0;
            st_state_err <= 1'b0;
            st_data_err  <= 1'b0;
            alert_prog   <= 1'b0;
            alert_state  <= 1'b0;
            init_ack     <= 1'b0;
            esc_en       <= 1'b0;
        end else begin
            st_ok        <= st_ok        | ev_done;
            st_cnt_err   <= st_cnt_err   | ev_cnt_err;
            st_trans_err <= st_trans_err | ev_arc_err;
            st_tok_err   <= st_tok_err   | ev_tok_err;
            st_prog_err  <= st_prog_err  | ev_prog_fail;
            st_state_err <= st_state_err | ev_init_bad | ev_fsm_bad;
            st_data_err  <= pers_err;
            alert_prog   <= ev_prog_fail;
            alert_state  <= ev_init_bad | ev_fsm_bad;
            init_ack     <= ev_init_ok;
            esc_en       <= esc_en | esc_in;
        end
    end

    // outputs
    always_comb begin
        lc_en_t en;
        en = idx2en(cur_idx_q);
        st_ready   = (fsm_q == F_IDLE);
        st_busy    = (fsm_q == F_CNTW) || (fsm_q == F_STW);
        prog_req   = st_busy;
        prog_state = pstate_q;
        prog_count = pcnt_q;
        dbg_en     = st_ready && en.dbg;
        func_en    = st_ready && en.func;
        key_en     = st_ready && en.key;
        cur_state  = valid_q ? idx2code(cur_idx_q) : '0;
        cur_count  = valid_q ? cnt_q : '0;
    end

endmodule

// File: rtl/lcx_ctrl_chk.sv
module lcx_ctrl_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             esc_in,
    input logic             prog_ack,
    input logic             prog_req,
    input logic [15:0]      prog_state,
    input logic [CNT_W-1:0] prog_count,
    input logic             st_ready,
    input logic             st_busy,
    input logic             dbg_en,
    input logic             func_en,
    input logic             key_en,
    input logic             esc_en,
    input logic             st_ok,
    input logic             st_cnt_err,
    input logic             st_trans_err,
    input logic             st_tok_err,
    input logic             st_prog_err,
    input logic             st_state_err,
    input logic             alert_prog,
    input logic             alert_state
);

    // R1
    idle_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> !(dbg_en || func_en || key_en));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ok || st_cnt_err || st_trans_err || st_tok_err) |->
            (!st_ready && !dbg_en && !func_en && !key_en));

    // R5
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_ok, st_cnt_err, st_trans_err, st_tok_err}));

    // R12
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || st_busy) |-> !st_ready);

    // R12
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !prog_ack && !esc_in) |=> ($stable(prog_state) && $stable(prog_count)));

    // R8
    prog_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_prog_err) |-> alert_prog);

    // R8
    prog_alert_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_prog |-> st_prog_err);

    // R9
    state_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_state_err) |-> (alert_state && !st_ready));

    // R11
    esc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_in |=> esc_en);

    // R11
    esc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_en |=> esc_en);

    // R11
    esc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_en |-> (!st_ready && !st_busy && !prog_req));

endmodule

bind lcx_ctrl lcx_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_lcx_ctrl.sv
module sim_lcx_ctrl;

    localparam int TW = 32;
    localparam int CW = 5;

    localparam logic [15:0] K_BLANK = 16'h5A1E;
    localparam logic [15:0] K_TEST  = 16'hA3C5;
    localparam logic [15:0] K_DEV   = 16'h3C96;
    localparam logic [15:0] K_PROD  = 16'hC969;
    localparam logic [15:0] K_RMA   = 16'h96F0;
    localparam logic [15:0] K_SCRAP = 16'h6F0F;
    localparam logic [TW-1:0] TOK   = 32'hC0DE_1234;

    // result: 0 ok, 1 count error, 2 arc error, 3 token error
    typedef struct packed {
        logic [15:0] init_code;
        logic [4:0]  cnt;
        logic [15:0] tgt;
        logic        tok_ok;
        logic [1:0]  res;
        logic [2:0]  en;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{K_BLANK, 5'd0,  K_TEST,   1'b0, 2'd0, 3'b000},
        '{K_TEST,  5'd3,  K_DEV,    1'b1, 2'd0, 3'b100},
        '{K_TEST,  5'd3,  K_DEV,    1'b0, 2'd3, 3'b100},
        '{K_DEV,   5'd5,  K_PROD,   1'b1, 2'd0, 3'b010},
        '{K_PROD,  5'd15, K_RMA,    1'b1, 2'd0, 3'b011},
        '{K_PROD,  5'd16, K_RMA,    1'b1, 2'd1, 3'b011},
        '{K_PROD,  5'd2,  K_TEST,   1'b1, 2'd2, 3'b011},
        '{K_RMA,   5'd7,  K_SCRAP,  1'b0, 2'd0, 3'b111},
        '{K_DEV,   5'd4,  16'h1234, 1'b1, 2'd2, 3'b010},
        '{K_SCRAP, 5'd9,  K_SCRAP,  1'b1, 2'd2, 3'b000},
        '{K_BLANK, 5'd16, K_DEV,    1'b0, 2'd1, 3'b000},
        '{K_TEST,  5'd1,  K_SCRAP,  1'b0, 2'd0, 3'b100},
        '{K_DEV,   5'd6,  K_RMA,    1'b0, 2'd3, 3'b010}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic init_req, pers_valid, pers_err, req_start, prog_ack, prog_err, esc_in;
    logic [15:0] pers_state, req_target, prog_state, cur_state;
    logic [CW-1:0] pers_count, prog_count, cur_count;
    logic [TW-1:0] req_token, exp_token;
    logic init_ack, prog_req, esc_en, dbg_en, func_en, key_en;
    logic st_ready, st_busy, st_ok, st_cnt_err, st_trans_err, st_tok_err;
    logic st_prog_err, st_state_err, st_data_err, alert_prog, alert_state;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lcx_ctrl #(.TOKEN_W(TW), .CNT_MAX(16)) u0 (
        .clk, .rst_n, .init_req, .pers_valid, .pers_state, .pers_count, .pers_err,
        .init_ack, .req_start, .req_target, .req_token, .exp_token,
        .prog_req, .prog_state, .prog_count, .prog_ack, .prog_err,
        .esc_in, .esc_en, .dbg_en, .func_en, .key_en, .cur_state, .cur_count,
        .st_ready, .st_busy, .st_ok, .st_cnt_err, .st_trans_err, .st_tok_err,
        .st_prog_err, .st_state_err, .st_data_err, .alert_prog, .alert_state
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        init_req = 0; pers_valid = 0; pers_err = 0; req_start = 0;
        prog_ack = 0; prog_err = 0; esc_in = 0;
        pers_state = '0; pers_count = '0; req_target = '0;
        req_token = '0; exp_token = TOK;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic do_init(input logic [15:0] code, input logic [CW-1:0] cnt);
        pers_state = code; pers_count = cnt; pers_valid = 1'b1; init_req = 1'b1;
        tick();
        init_req = 1'b0; pers_valid = 1'b0;
    endtask

    task automatic send_req(input logic [15:0] tgt, input logic [TW-1:0] tok);
        req_target = tgt; req_token = tok; req_start = 1'b1;
        tick();
        req_start = 1'b0;
    endtask

    task automatic ack(input logic err);
        prog_ack = 1'b1; prog_err = err;
        tick();
        prog_ack = 1'b0; prog_err = 1'b0;
    endtask

    function automatic logic [3:0] res_bits(input logic [1:0] r);
        case (r)
            2'd0:    return 4'b1000;
            2'd1:    return 4'b0100;
            2'd2:    return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [3:0] verdicts();
        return {st_ok, st_cnt_err, st_trans_err, st_tok_err};
    endfunction

    function automatic logic [2:0] ens();
        return {dbg_en, func_en, key_en};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [3:0]  held;
        logic [15:0] exp_code;
        logic [CW-1:0] exp_cnt;

        // ---------- R1: reset state ----------
        do_reset();
        chk("R1 ready", st_ready, 0);
        chk("R1 enables", ens(), 0);
        chk("R1 cur_state", cur_state, 0);
        chk("R1 prog_req/busy/ack", {prog_req, st_busy, init_ack}, 0);
        init_req = 1'b1; pers_state = K_PROD;
        tick(); tick();
        chk("R1 waits without pers_valid", st_ready, 0);
        init_req = 1'b0;

        // ---------- vector table: R2..R7 ----------
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            do_reset();
            do_init(v.init_code, v.cnt);
            chk($sformatf("R2 v%0d ready", i), st_ready, 1);
            chk($sformatf("R2 v%0d init_ack", i), init_ack, 1);
            chk($sformatf("R2 v%0d cur_state", i), cur_state, v.init_code);
            chk($sformatf("R2 v%0d cur_count", i), cur_count, v.cnt);
            chk($sformatf("R2 v%0d enables", i), ens(), v.en);
            send_req(v.tgt, v.tok_ok ? TOK : (TOK ^ 32'h1));
            chk($sformatf("R2 v%0d init_ack pulse", i), init_ack, 0);
            if (v.res == 2'd0) begin
                chk($sformatf("R6 v%0d req/busy", i), {prog_req, st_busy}, 2'b11);
                chk($sformatf("R6 v%0d count write", i), prog_count, v.cnt + 5'd1);
                chk($sformatf("R6 v%0d old state", i), prog_state, v.init_code);
                chk($sformatf("R12 v%0d enables off", i), ens(), 0);
                ack(1'b0);
                chk($sformatf("R6 v%0d state write", i), prog_state, v.tgt);
                chk($sformatf("R6 v%0d count consumed", i), cur_count, v.cnt + 5'd1);
                chk($sformatf("R12 v%0d still busy", i), prog_req, 1);
                ack(1'b0);
            end else begin
                chk($sformatf("R3 R4 R5 v%0d no prog", i), prog_req, 0);
            end
            chk($sformatf("R3 R4 R5 v%0d verdict", i), verdicts(), res_bits(v.res));
            chk($sformatf("R7 v%0d quiet", i), {ens(), st_ready, prog_req}, 0);
            exp_code = (v.res == 2'd0) ? v.tgt : v.init_code;
            exp_cnt  = (v.res == 2'd0) ? v.cnt + 5'd1 : v.cnt;
            chk($sformatf("R6 v%0d cur_state", i), cur_state, exp_code);
            chk($sformatf("R6 v%0d cur_count", i), cur_count, exp_cnt);
            held = verdicts();
            send_req(K_SCRAP, TOK);
            chk($sformatf("R7 v%0d ignored req", i), prog_req, 0);
            chk($sformatf("R7 v%0d status held", i), verdicts(), held);
            chk($sformatf("R7 v%0d state held", i), {cur_state, 3'b0, cur_count}, {exp_code, 3'b0, exp_cnt});
        end

        // ---------- R8: error on count write ----------
        do_reset();
        do_init(K_PROD, 5'd4);
        send_req(K_RMA, TOK);
        ack(1'b1);
        chk("R8 count-write prog err", {st_prog_err, alert_prog}, 2'b11);
        chk("R8 escalated quiet", {ens(), st_ready, prog_req}, 0);
        chk("R8 count unchanged", cur_count, 4);
        tick();
        chk("R8 alert pulse ends", alert_prog, 0);

        // ---------- R8: error on state write ----------
        do_reset();
        do_init(K_PROD, 5'd4);
        send_req(K_RMA, TOK);
        ack(1'b0);
        ack(1'b1);
        chk("R8 state-write prog err", {st_prog_err, alert_prog, st_ok}, 3'b110);
        chk("R8 count consumed", cur_count, 5);
        chk("R8 state not moved", cur_state, K_PROD);

        // ---------- R9: bad persisted data ----------
        do_reset();
        do_init(16'h1111, 5'd2);
        chk("R9 bad code", {st_state_err, alert_state, st_ready, init_ack}, 4'b1100);
        tick();
        chk("R9 alert pulse ends", {alert_state, st_state_err}, 2'b01);
        do_reset();
        do_init(K_DEV, 5'd17);
        chk("R9 count above limit", {st_state_err, alert_state, st_ready}, 3'b110);
        chk("R9 enables off", ens(), 0);

        // ---------- R10: data error flag ----------
        do_reset();
        pers_err = 1'b1;
        do_init(K_TEST, 5'd2);
        chk("R10 flag reported", {st_data_err, st_ready}, 2'b11);
        pers_err = 1'b0;
        tick();
        chk("R10 flag clears", {st_data_err, st_ready}, 2'b01);
        send_req(K_DEV, TOK);
        ack(1'b0); ack(1'b0);
        chk("R10 transition unaffected", {st_ok, cur_state}, {1'b1, K_DEV});

        // ---------- R11: escalation while idle ----------
        do_reset();
        do_init(K_RMA, 5'd3);
        esc_in = 1'b1;
        tick();
        esc_in = 1'b0;
        chk("R11 esc_en set", esc_en, 1);
        chk("R11 quiet", {ens(), st_ready, st_busy}, 0);
        tick(); tick();
        chk("R11 esc_en sticky", esc_en, 1);
        send_req(K_SCRAP, TOK);
        chk("R11 req ignored", {prog_req, st_ok}, 0);

        // ---------- R11: escalation during programming ----------
        do_reset();
        chk("R11 reset clears esc_en", esc_en, 0);
        do_init(K_DEV, 5'd1);
        send_req(K_PROD, TOK);
        chk("R12 writing", prog_req, 1);
        esc_in = 1'b1; prog_ack = 1'b1;
        tick();
        esc_in = 1'b0; prog_ack = 1'b0;
        chk("R11 pending write dropped", {prog_req, st_busy, esc_en}, 3'b001);
        chk("R11 count not consumed", cur_count, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule